// File: doc/BRIEF.md
# Pipelined Converter Code Corrector

This block sits behind the analog part of a three-stage pipelined analog-to-digital converter. It collects the raw comparator codes the stages produce for each sample and merges them into one 8-bit word per clock. The first and second stages each deliver a 3-bit code, and the third stage delivers a 4-bit code. Because the residue between stages is amplified by four, each of the first two stages contributes two bits of weight plus one redundant bit. A comparator decision that lands on the wrong side of a threshold is therefore absorbed by the later stages when the codes are added with overlapping weights.

The stages settle half a clock apart. The first and third codes are captured on falling edges and the second code on a rising edge. Skew registers bring the three codes of one sample together in a single adder cycle. The sum has a fixed offset removed, is clamped to the 8-bit range and is registered into an output latch. The latch drives the data pins only while the active-low output enable is held low. The word for a sample appears three clocks after the sample, and a new word follows on every clock.

Top module: `adc_pipe_corrector`

## Requirements
- R1: While `rst` is high at a rising edge, the following cycle shows `valid_o` low and a zero word on `data_o` (when `oe_n` is low).
- R2: If e0 is the first rising edge that samples `rst` low, `valid_o` stays low after e0, e0+1 and e0+2, rises after e0+3, and stays high from then on.
- R3: Sample k presents its three codes at fixed points. `code1_i` is taken on the falling edge that follows rising edge k. `code2_i` is taken on rising edge k+1. `code3_i` is taken on the falling edge that follows rising edge k+1. The word for sample k is on `data_o` after rising edge k+3, and every later clock carries the next sample's word.
- R4: The word equals 32*code1 + 8*code2 + code3 - OFFSET_LSB when that value lies in 0..255. OFFSET_LSB defaults to 20.
- R5: When that value is below 0, the word is 0.
- R6: When that value is above 255, the word is 255. For example, all codes at their maximum give 255.
- R7: Some codes carry a redundant-bit error: a stage code moved by one step up or down, with the next stage's code absorbing the difference. Such codes give the same word as the error-free codes of the same input level.
- R8: While `oe_n` is high, `data_o` is released to high impedance. While it is low, `data_o` is driven. The conversion pipeline keeps running either way, so the first word after re-enabling belongs to the sample three clocks earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; stages settle on both of its edges |
| rst | input | 1 | Synchronous active-high reset |
| oe_n | input | 1 | Active-low output enable for the data pins |
| code1_i | input | 3 | First-stage code, captured on a falling edge |
| code2_i | input | 3 | Second-stage code, captured on a rising edge |
| code3_i | input | 4 | Third-stage code, captured on a falling edge |
| data_o | output | 8 | Corrected word, bit 7 most significant; high impedance when disabled |
| valid_o | output | 1 | High once the pipeline has filled after reset |

## Verification
A sample's codes are driven 1 ns after the edge that precedes their capture edge. The first code and the third code follow rising edges, and the second code follows a falling edge. A queue indexed by sample holds the ideal quantisation of the level that produced those codes. The word for sample k is compared 1 ns after rising edge k+3, which is after the second-stage register, the adder register and the output latch have each taken one rising edge. The valid flag is checked on the same schedule from the first edge that samples reset low, and enable changes are made half a cycle before the rising edge whose word they affect.

// File: rtl/adcec_pkg.sv
package adcec_pkg;

    // Stage code widths and the output word width.
    localparam int unsigned S1_BITS   = 3;
    localparam int unsigned S2_BITS   = 3;
    localparam int unsigned S3_BITS   = 4;
    localparam int unsigned WORD_BITS = 8;

    // Each stage overlaps the next by one redundant bit.
    localparam int unsigned S2_SHIFT = S3_BITS - 1;
    localparam int unsigned S1_SHIFT = S2_SHIFT + S2_BITS - 1;
    localparam int unsigned SUM_BITS = WORD_BITS + 3;

    typedef struct packed {
        logic [S1_BITS-1:0] c1;
        logic [S2_BITS-1:0] c2;
        logic [S3_BITS-1:0] c3;
    } stage_set_t;

    typedef logic signed [SUM_BITS-1:0] raw_sum_t;
    typedef logic [WORD_BITS-1:0]       word_t;

    localparam raw_sum_t WORD_MAX = raw_sum_t'((1 << WORD_BITS) - 1);

    // Weighted sum of one sample's codes with the fixed offset removed.
    function automatic raw_sum_t merge_codes(stage_set_t s, int unsigned offset);
        logic [SUM_BITS-1:0] acc;
        acc = (SUM_BITS'(s.c1) << S1_SHIFT)
            + (SUM_BITS'(s.c2) << S2_SHIFT)
            + SUM_BITS'(s.c3);
        return raw_sum_t'(acc) - raw_sum_t'(offset);
    endfunction

    // Clamp a signed sum into the unsigned word range.
    function automatic word_t saturate_word(raw_sum_t v);
        if (v < 0)
            return '0;
        else if (v > WORD_MAX)
            return '1;
        else
            return v[WORD_BITS-1:0];
    endfunction

endpackage

// File: rtl/adcec_stage_align.sv
module adcec_stage_align
    import adcec_pkg::*;
#(
    parameter int unsigned FILL_DEPTH = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [S1_BITS-1:0] c1_i,
    input  logic [S2_BITS-1:0] c2_i,
    input  logic [S3_BITS-1:0] c3_i,
    output stage_set_t         set_o,
    output logic               set_valid_o
);

    logic [S1_BITS-1:0]    c1_fall;
    logic [S1_BITS-1:0]    c1_rise;
    logic [S2_BITS-1:0]    c2_rise;
    logic [S3_BITS-1:0]    c3_fall;
    logic [FILL_DEPTH-1:0] fill;

    // Falling-edge capture for the first and third stages.
    always_ff @(negedge clk) begin
        if (rst) begin
            c1_fall <= '0;
            c3_fall <= '0;
        end else begin
            c1_fall <= c1_i;
            c3_fall <= c3_i;
        end
    end

    // Rising-edge capture: the second stage, plus the skew register that
    // holds the first stage's code until the third stage settles.
    always_ff @(posedge clk) begin
        if (rst) begin
            c1_rise <= '0;
            c2_rise <= '0;
        end else begin
            c1_rise <= c1_fall;
            c2_rise <= c2_i;
        end
    end

    // Fill tracker: marks when aligned codes belong to a post-reset sample.
    for (genvar i = 0; i < FILL_DEPTH; i++) begin : g_fill
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) fill[i] <= 1'b0;
                else     fill[i] <= 1'b1;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst) fill[i] <= 1'b0;
                else     fill[i] <= fill[i-1];
            end
        end
    end

    always_comb begin
        set_o.c1 = c1_rise;
        set_o.c2 = c2_rise;
        set_o.c3 = c3_fall;
    end

    assign set_valid_o = fill[FILL_DEPTH-1];

endmodule

// File: rtl/adcec_merge.sv
module adcec_merge
    import adcec_pkg::*;
#(
    parameter int unsigned OFFSET_LSB = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  stage_set_t set_i,
    input  logic       set_valid_i,
    output word_t      word_o,
    output logic       word_valid_o
);

    raw_sum_t raw;

    assign raw = merge_codes(set_i, OFFSET_LSB);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_o       <= '0;
            word_valid_o <= 1'b0;
        end else begin
            word_o       <= saturate_word(raw);
            word_valid_o <= set_valid_i;
        end
    end

    // R4: an in-range sum passes through unchanged
    a_r4_in_range: assert property (@(posedge clk) disable iff (rst)
        (raw >= 0 && raw <= WORD_MAX) |=> (word_o == $past(raw[WORD_BITS-1:0])));

    // R5: a negative sum saturates at zero
    a_r5_clamp_low: assert property (@(posedge clk) disable iff (rst)
        (raw < 0) |=> (word_o == '0));

    // R6: a sum above the word range saturates at full scale
    a_r6_clamp_high: assert property (@(posedge clk) disable iff (rst)
        (raw > WORD_MAX) |=> (word_o == '1));

endmodule

// File: rtl/adcec_out_latch.sv
module adcec_out_latch
    import adcec_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 oe_n,
    input  word_t                word_i,
    input  logic                 word_valid_i,
    output logic [WORD_BITS-1:0] data_o,
    output logic                 valid_o
);

    word_t word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            valid_o <= 1'b0;
        end else begin
            word_q  <= word_i;
            valid_o <= word_valid_i;
        end
    end

    assign data_o = oe_n ? {WORD_BITS{1'bz}} : word_q;

    // R2: valid rises only after three reset-free rising edges
    a_r2_fill_latency: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_o) |-> (!$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3)));

    // R2: once filled, valid holds until the next reset
    a_r2_valid_holds: assert property (@(posedge clk) disable iff (rst)
        $past(valid_o) |-> valid_o);

endmodule

// File: rtl/adc_pipe_corrector.sv
module adc_pipe_corrector
    import adcec_pkg::*;
#(
    parameter int unsigned OFFSET_LSB = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 oe_n,
    input  logic [S1_BITS-1:0]   code1_i,
    input  logic [S2_BITS-1:0]   code2_i,
    input  logic [S3_BITS-1:0]   code3_i,
    output logic [WORD_BITS-1:0] data_o,
    output logic                 valid_o
);

    stage_set_t aligned;
    logic       aligned_valid;
    word_t      merged;
    logic       merged_valid;

    adcec_stage_align #(
        .FILL_DEPTH (2)
    ) u_align (
        .clk         (clk),
        .rst         (rst),
        .c1_i        (code1_i),
        .c2_i        (code2_i),
        .c3_i        (code3_i),
        .set_o       (aligned),
        .set_valid_o (aligned_valid)
    );

    adcec_merge #(
        .OFFSET_LSB (OFFSET_LSB)
    ) u_merge (
        .clk          (clk),
        .rst          (rst),
        .set_i        (aligned),
        .set_valid_i  (aligned_valid),
        .word_o       (merged),
        .word_valid_o (merged_valid)
    );

    adcec_out_latch u_latch (
        .clk          (clk),
        .rst          (rst),
        .oe_n         (oe_n),
        .word_i       (merged),
        .word_valid_i (merged_valid),
        .data_o       (data_o),
        .valid_o      (valid_o)
    );

endmodule

// File: tb/tb_adc_pipe_corrector.sv
`timescale 1ns/1ps
module tb_adc_pipe_corrector;

    localparam int NS = 400;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       oe_n = 1'b0;
    logic [2:0] c1 = '0;
    logic [2:0] c2 = '0;
    logic [3:0] c3 = '0;
    wire  [7:0] dbus;
    wire        vld;

    always #2 clk = ~clk;   // 250 MHz

    for (genvar g = 0; g < 8; g++) begin : g_pull
        pullup (dbus[g]);
    end

    adc_pipe_corrector dut (
        .clk     (clk),
        .rst     (rst),
        .oe_n    (oe_n),
        .code1_i (c1),
        .code2_i (c2),
        .code3_i (c3),
        .data_o  (dbus),
        .valid_o (vld)
    );

    int         checks = 0;
    int         fails  = 0;
    bit         done   = 0;
    logic [2:0] s1q[$];
    logic [2:0] s2q[$];
    logic [3:0] s3q[$];
    int         expq[$];
    string      tagq[$];

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int clampi(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    // Behavioural model of the three quantisers for an integer input level
    // (in output LSBs), with optional one-step comparator errors.
    function automatic void add_sample(int a, int e1, int e2);
        int s1, r1, v, s2, r2, s3;
        bit hit;
        hit = 0;
        s1 = clampi(a / 32, 0, 7);
        r1 = a - 32 * s1;
        if (e1 != 0 && s1 + e1 >= 0 && s1 + e1 <= 7 &&
            r1 - 32 * e1 >= -16 && r1 - 32 * e1 <= 47) begin
            s1 += e1; r1 -= 32 * e1; hit = 1;
        end
        v  = r1 + 16;
        s2 = clampi(v / 8, 0, 7);
        r2 = v - 8 * s2;
        if (e2 != 0 && s2 + e2 >= 0 && s2 + e2 <= 7 &&
            r2 - 8 * e2 >= -4 && r2 - 8 * e2 <= 11) begin
            s2 += e2; r2 -= 8 * e2; hit = 1;
        end
        s3 = clampi(r2 + 4, 0, 15);
        s1q.push_back(3'(s1));
        s2q.push_back(3'(s2));
        s3q.push_back(4'(s3));
        expq.push_back(clampi(a, 0, 255));
        if (a < 0)       tagq.push_back("R5");
        else if (a > 255) tagq.push_back("R6");
        else if (hit)    tagq.push_back("R7");
        else             tagq.push_back("R4");
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        bit was_off;
        // Directed levels: ends, midscale, out-of-range, boundaries.
        add_sample(0, 0, 0);
        add_sample(255, 0, 0);
        add_sample(128, 0, 0);
        add_sample(-1, 0, 0);
        add_sample(256, 0, 0);
        add_sample(-24, 0, 0);
        add_sample(279, 0, 0);   // all codes at maximum
        add_sample(31, 0, 0);
        add_sample(32, 0, 0);
        add_sample(40, -1, 0);   // stage one reads low
        add_sample(60, 1, 0);    // stage one reads high
        add_sample(100, 0, 1);
        add_sample(101, 0, -1);
        add_sample(250, 1, 1);
        while (expq.size() < NS)
            add_sample(int'($urandom_range(303)) - 24,
                       int'($urandom_range(2)) - 1,
                       int'($urandom_range(2)) - 1);

        // R1: reset state
        repeat (3) begin
            @(posedge clk); #1;
            check("R1", int'(vld), 0);
            check("R1", int'(dbus), 0);
        end
        @(posedge clk); #1 rst = 1'b0;

        was_off = 0;
        for (int k = 0; k < NS + 3; k++) begin
            @(posedge clk); #1;
            // R2: fill latency of three edges after reset release
            check("R2", int'(vld), (k >= 3) ? 1 : 0);
            if (k >= 3) begin
                if (oe_n) begin
                    check("R8", int'(dbus), 255);
                    was_off = 1;
                end else if (was_off) begin
                    check("R8", int'(dbus), expq[k-3]);
                    was_off = 0;
                end else if (k == 3) begin
                    check("R3", int'(dbus), expq[0]);
                end else begin
                    check(tagq[k-3], int'(dbus), expq[k-3]);
                end
            end
            if (k < NS)                c1 = s1q[k];
            if (k > 0 && k - 1 < NS)   c3 = s3q[k-1];
            @(negedge clk); #1;
            if (k < NS) c2 = s2q[k];
            oe_n = (k >= 100 && k < 106);
        end

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule